// File: doc/BRIEF.md
# Per-Requester Aperture Address Decoder

This block routes the requests of several bus requesters to a fixed set of memory and peripheral targets. The top four address bits of a request pick one of sixteen apertures. For each requester and each aperture, a programmable 4-bit target code selects the destination. A programmable 4-bit replacement nibble takes the place of the aperture bits, so the target sees a translated address. Every requester decodes in parallel and through its own map. The block returns a one-hot target select, a decode-error flag and the translated address for each requester.

Software programs the maps through a word-addressed register port. Each requester owns a group of eight words. Writes to a group land in shadow registers, and reads return those shadow values. The decode logic uses only the active copy. A small two-state commit machine per requester copies shadow into active after an update write. It has two states:
- `CM_IDLE`: waiting. It moves to `CM_APPLY` on a write of value 1 to the group's update word.
- `CM_APPLY`: the cycle in which shadow is copied to active. It returns to `CM_IDLE` unless another qualifying update write arrives in that cycle, in which case it stays in `CM_APPLY`.

One requester also carries a boot-mirror control. While that control is set, it takes over that requester's first aperture.

Top module: `aper_xbar_decoder`

## Requirements
- R1: After reset, every select nibble of every requester reads 0. Offset word 0 reads 0x76543210 and offset word 1 reads 0xFEDCBA98, which gives each aperture n an offset nibble of n. The boot control reads 3.
- R2: Register word address m*8+w addresses requester m, word w. w=0 holds select nibbles for apertures 0..7 and w=1 for apertures 8..15. w=2 and w=3 hold the offset nibbles in the same arrangement. Aperture k uses bits [4k'+3:4k'] with k'=k mod 8. Reads return the shadow value, and unmapped words read 0.
- R3: A write to a select or offset word does not change any decode output until that requester commits.
- R4: A write of value 1 to word 5 of a group commits that group's shadow into the active map. Outputs change from the second rising edge after the write is taken, not the first. A write of any other value to word 5 commits nothing.
- R5: The aperture is request address bits [31:28]. An active select code c in 1..10 drives only bit c-1 of that requester's 10-bit target select.
- R6: A code of 0, or any code from 11 to 15, raises the requester's decode error and drives no target select bit.
- R7: The translated address is the aperture's active offset nibble in bits [31:28] followed by request bits [27:0].
- R8: Requester 0 has a boot control at word 4, bits [1:0]. The control takes effect on the edge that takes the write. While it is nonzero, aperture 0 of requester 0 selects target code 5 and passes the address through unchanged. When it is zero, the normal map applies.
- R9: When a requester's valid input is low, its target select and decode error are both 0.
- R10: A commit to one requester leaves the active map of every other requester unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Register word address to write |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 7 | Register word address to read |
| rd_data | output | 32 | Shadow value at rd_addr |
| req_valid | input | 12 | Per-requester request valid |
| req_addr | input | 384 | Request addresses, requester m in bits [32m+31:32m] |
| tgt_sel | output | 120 | One-hot target selects, requester m in bits [10m+9:10m] |
| dec_err | output | 12 | Per-requester decode error |
| xlat_addr | output | 384 | Translated addresses, requester m in bits [32m+31:32m] |

## Verification
The bench sweeps all sixteen apertures of all twelve requesters at once, and it does so at each stage of the register life cycle.

After shadow writes with no commit, the outputs must stay as they were. A design that decodes from shadow would change its outputs early. The bench then writes an update value other than 1; a design that commits on any update write would change its outputs there. The bench also samples one requester in the cycle straight after its update write, where the old map must still apply, and again one cycle later; this catches a design that commits a cycle early or a cycle late. One requester is left uncommitted to catch commits that leak across groups.

The patterns cover select codes 11 to 15 and 0, so a design that lets an unused code through to a select bit is reported. The boot control is set, cleared and set again, so a mirror that never releases, or that also touches another requester, shows up in the aperture 0 results.

// File: rtl/aper_pkg.sv
package aper_pkg;
    localparam int APER_N  = 16;
    localparam int NIB_W   = 4;
    localparam int MAP_W   = APER_N * NIB_W;

    // word index inside one requester group
    localparam logic [2:0] W_SEL_LO = 3'd0;
    localparam logic [2:0] W_SEL_HI = 3'd1;
    localparam logic [2:0] W_OFF_LO = 3'd2;
    localparam logic [2:0] W_OFF_HI = 3'd3;
    localparam logic [2:0] W_BOOT   = 3'd4;
    localparam logic [2:0] W_UPD    = 3'd5;

    typedef enum logic {
        CM_IDLE  = 1'b0,
        CM_APPLY = 1'b1
    } commit_st_e;

    function automatic logic [MAP_W-1:0] ident_map();
        logic [MAP_W-1:0] v;
        for (int i = 0; i < APER_N; i++) begin
            v[i*NIB_W +: NIB_W] = NIB_W'(i);
        end
        return v;
    endfunction
endpackage

// File: rtl/aper_regbank.sv
module aper_regbank
    import aper_pkg::*;
#(
    parameter bit         HAS_BOOT = 1'b0,
    parameter logic [1:0] BOOT_RST = 2'b11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_word,
    input  logic [31:0]      wr_data,
    input  logic [2:0]       rd_word,
    output logic [31:0]      rd_data,
    output logic [MAP_W-1:0] act_sel,
    output logic [MAP_W-1:0] act_off,
    output logic             boot_on
);
    localparam logic [MAP_W-1:0] OFF_RST = ident_map();

    commit_st_e       st_q, st_nx;
    logic [MAP_W-1:0] sh_sel, sh_off;
    logic [1:0]       boot_q;
    logic             upd_hit;

    assign upd_hit = wr_en && (wr_word == W_UPD) && (wr_data == 32'd1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CM_IDLE;
        else        st_q <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            CM_IDLE:  st_nx = upd_hit ? CM_APPLY : CM_IDLE;
            CM_APPLY: st_nx = upd_hit ? CM_APPLY : CM_IDLE;
            default:  st_nx = CM_IDLE;
        endcase
    end

    // shadow registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_sel <= '0;
            sh_off <= OFF_RST;
        end else if (wr_en) begin
            unique case (wr_word)
                W_SEL_LO: sh_sel[31:0]  <= wr_data;
                W_SEL_HI: sh_sel[63:32] <= wr_data;
                W_OFF_LO: sh_off[31:0]  <= wr_data;
                W_OFF_HI: sh_off[63:32] <= wr_data;
                default:  ;
            endcase
        end
    end

    // active registers, driven by the commit state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_sel <= '0;
            act_off <= OFF_RST;
        end else if (st_q == CM_APPLY) begin
            act_sel <= sh_sel;
            act_off <= sh_off;
        end
    end

    generate
        if (HAS_BOOT) begin : g_boot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                            boot_q <= BOOT_RST;
                else if (wr_en && wr_word == W_BOOT)   boot_q <= wr_data[1:0];
            end
        end else begin : g_noboot
            assign boot_q = 2'b00;
        end
    endgenerate

    assign boot_on = |boot_q;

    always_comb begin
        rd_data = '0;
        unique case (rd_word)
            W_SEL_LO: rd_data = sh_sel[31:0];
            W_SEL_HI: rd_data = sh_sel[63:32];
            W_OFF_LO: rd_data = sh_off[31:0];
            W_OFF_HI: rd_data = sh_off[63:32];
            W_BOOT:   rd_data = HAS_BOOT ? {30'd0, boot_q} : 32'd0;
            default:  rd_data = '0;
        endcase
    end

    assert_commit_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CM_APPLY) |=> (act_sel == $past(sh_sel) && act_off == $past(sh_off)));

    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CM_IDLE) |=> ($stable(act_sel) && $stable(act_off)));
endmodule

// File: rtl/aper_lookup.sv
module aper_lookup
    import aper_pkg::*;
#(
    parameter int         ADDR_W    = 32,
    parameter int         NUM_TGT   = 10,
    parameter logic [3:0] BOOT_CODE = 4'd5
) (
    input  logic               valid,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [MAP_W-1:0]   act_sel,
    input  logic [MAP_W-1:0]   act_off,
    input  logic               boot_on,
    output logic [NUM_TGT-1:0] tgt_sel,
    output logic               dec_err,
    output logic [ADDR_W-1:0]  xlat
);
    logic [NIB_W-1:0]   aper, code;
    logic [NUM_TGT-1:0] hot;
    logic               code_ok, mirror;

    assign aper   = addr[ADDR_W-1 -: NIB_W];
    assign mirror = boot_on && (aper == '0);

    always_comb begin
        if (mirror) begin
            code = BOOT_CODE;
            xlat = addr;
        end else begin
            code = act_sel[aper*NIB_W +: NIB_W];
            xlat = {act_off[aper*NIB_W +: NIB_W], addr[ADDR_W-NIB_W-1:0]};
        end
    end

    genvar t;
    generate
        for (t = 0; t < NUM_TGT; t++) begin : g_hot
            assign hot[t] = (code == NIB_W'(t + 1));
        end
    endgenerate

    assign code_ok = (code != '0) && (int'(code) <= NUM_TGT);
    assign tgt_sel = (valid && code_ok) ? hot : '0;
    assign dec_err = valid && !code_ok;

    always_comb begin
        assert_onehot_R5: assert ($onehot0(tgt_sel));
        assert_err_quiet_R6: assert (!(dec_err && (tgt_sel != '0)));
    end
endmodule

// File: rtl/aper_xbar_decoder.sv
module aper_xbar_decoder
    import aper_pkg::*;
#(
    parameter int         NUM_REQ   = 12,
    parameter int         ADDR_W    = 32,
    parameter int         NUM_TGT   = 10,
    parameter int         BOOT_REQ  = 0,
    parameter logic [3:0] BOOT_CODE = 4'd5,
    localparam int        GRP_W     = $clog2(NUM_REQ),
    localparam int        WA_W      = GRP_W + 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [WA_W-1:0]            wr_addr,
    input  logic [31:0]                wr_data,
    input  logic [WA_W-1:0]            rd_addr,
    output logic [31:0]                rd_data,
    input  logic [NUM_REQ-1:0]         req_valid,
    input  logic [NUM_REQ*ADDR_W-1:0]  req_addr,
    output logic [NUM_REQ*NUM_TGT-1:0] tgt_sel,
    output logic [NUM_REQ-1:0]         dec_err,
    output logic [NUM_REQ*ADDR_W-1:0]  xlat_addr
);
    logic [GRP_W-1:0] wr_grp, rd_grp;
    logic [31:0]      rd_arr [NUM_REQ];

    assign wr_grp = wr_addr[WA_W-1:3];
    assign rd_grp = rd_addr[WA_W-1:3];

    genvar m;
    generate
        for (m = 0; m < NUM_REQ; m++) begin : g_req
            logic [MAP_W-1:0] a_sel, a_off;
            logic             b_on, hit;

            assign hit = wr_en && (wr_grp == GRP_W'(m));

            aper_regbank #(
                .HAS_BOOT (m == BOOT_REQ),
                .BOOT_RST (2'b11)
            ) i_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (hit),
                .wr_word (wr_addr[2:0]),
                .wr_data (wr_data),
                .rd_word (rd_addr[2:0]),
                .rd_data (rd_arr[m]),
                .act_sel (a_sel),
                .act_off (a_off),
                .boot_on (b_on)
            );

            aper_lookup #(
                .ADDR_W    (ADDR_W),
                .NUM_TGT   (NUM_TGT),
                .BOOT_CODE (BOOT_CODE)
            ) i_look (
                .valid   (req_valid[m]),
                .addr    (req_addr[m*ADDR_W +: ADDR_W]),
                .act_sel (a_sel),
                .act_off (a_off),
                .boot_on (b_on),
                .tgt_sel (tgt_sel[m*NUM_TGT +: NUM_TGT]),
                .dec_err (dec_err[m]),
                .xlat    (xlat_addr[m*ADDR_W +: ADDR_W])
            );

            assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
                !req_valid[m] |-> (tgt_sel[m*NUM_TGT +: NUM_TGT] == '0 && !dec_err[m]));

            assert_low_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
                req_valid[m] |-> (xlat_addr[m*ADDR_W +: ADDR_W-NIB_W]
                                  == req_addr[m*ADDR_W +: ADDR_W-NIB_W]));
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (rd_grp == GRP_W'(i)) rd_data = rd_arr[i];
        end
    end
endmodule

// File: tb/test_aper_xbar_decoder.sv
`timescale 1ns/1ps
module test_aper_xbar_decoder;
    localparam int NR = 12;
    localparam int NT = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [6:0]        wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [6:0]        rd_addr = '0;
    logic [31:0]       rd_data;
    logic [NR-1:0]     req_valid = '1;
    logic [NR*32-1:0]  req_addr = '0;
    logic [NR*NT-1:0]  tgt_sel;
    logic [NR-1:0]     dec_err;
    logic [NR*32-1:0]  xlat_addr;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [3:0] m_sel [NR][16];
    logic [3:0] m_off [NR][16];
    logic [1:0] m_boot;

    always #4 clk = ~clk;

    aper_xbar_decoder i_aper_xbar_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .req_valid(req_valid), .req_addr(req_addr), .tgt_sel(tgt_sel),
        .dec_err(dec_err), .xlat_addr(xlat_addr)
    );

    function automatic logic [3:0] pat_sel(int m, int n);
        return 4'((m * 7 + n * 3 + 1) % 16);
    endfunction

    function automatic logic [3:0] pat_off(int m, int n);
        return 4'((n * 5 + m * 3 + 2) % 16);
    endfunction

    function automatic logic [27:0] low_of(int m, int n);
        return 28'h0A00000 + 28'(m * 'h1010) + 28'(n * 7);
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 7'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(int a, logic [31:0] exp, string tag);
        @(negedge clk);
        rd_addr = 7'(a);
        #1;
        chk(rd_data == exp, tag, rd_data, exp);
    endtask

    // expected outputs for requester m at aperture n, from the model
    task automatic chk_one(int m, int n, string tag);
        logic [3:0]  code;
        logic [31:0] ex_x;
        logic [NT-1:0] ex_s;
        bit          ex_e;
        if (m == 0 && n == 0 && m_boot != 2'b00) begin
            code = 4'd5;                          // R8 mirror
            ex_x = {4'(n), low_of(m, n)};
        end else begin
            code = m_sel[m][n];
            ex_x = {m_off[m][n], low_of(m, n)};   // R7
        end
        if (code >= 1 && code <= NT) begin
            ex_s = NT'(1) << (code - 1);           // R5
            ex_e = 1'b0;
        end else begin
            ex_s = '0;                             // R6
            ex_e = 1'b1;
        end
        chk(tgt_sel[m*NT +: NT] == ex_s, {tag, " sel R5/R6"}, 64'(tgt_sel[m*NT +: NT]), 64'(ex_s));
        chk(dec_err[m] == ex_e, {tag, " err R6"}, 64'(dec_err[m]), 64'(ex_e));
        chk(xlat_addr[m*32 +: 32] == ex_x, {tag, " xlat R7"}, 64'(xlat_addr[m*32 +: 32]), 64'(ex_x));
    endtask

    task automatic sweep(string tag);
        for (int n = 0; n < 16; n++) begin
            @(negedge clk);
            for (int m = 0; m < NR; m++) req_addr[m*32 +: 32] = {4'(n), low_of(m, n)};
            #1;
            for (int m = 0; m < NR; m++) chk_one(m, n, tag);
        end
    endtask

    function automatic logic [31:0] pack(int m, bit hi, bit is_off);
        logic [31:0] w;
        for (int k = 0; k < 8; k++)
            w[k*4 +: 4] = is_off ? pat_off(m, k + (hi ? 8 : 0)) : pat_sel(m, k + (hi ? 8 : 0));
        return w;
    endfunction

    task automatic commit_model(int m);
        for (int n = 0; n < 16; n++) begin
            m_sel[m][n] = pat_sel(m, n);
            m_off[m][n] = pat_off(m, n);
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int m = 0; m < NR; m++)
            for (int n = 0; n < 16; n++) begin
                m_sel[m][n] = 4'd0;
                m_off[m][n] = 4'(n);
            end
        m_boot = 2'b11;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset readback
        rd_chk(0, 32'h0, "R1 sel lo req0");
        rd_chk(9, 32'h0, "R1 sel hi req1");
        rd_chk(2, 32'h76543210, "R1 off lo req0");
        rd_chk(11 * 8 + 3, 32'hFEDCBA98, "R1 off hi req11");
        rd_chk(4, 32'h3, "R1 boot reset");
        sweep("R1 reset map");

        // R2 shadow writes, R3 no effect yet
        for (int m = 0; m < NR; m++) begin
            wr(m * 8 + 0, pack(m, 0, 0));
            wr(m * 8 + 1, pack(m, 1, 0));
            wr(m * 8 + 2, pack(m, 0, 1));
            wr(m * 8 + 3, pack(m, 1, 1));
        end
        rd_chk(11 * 8 + 0, pack(11, 0, 0), "R2 readback sel lo");
        rd_chk(11 * 8 + 1, pack(11, 1, 0), "R2 readback sel hi");
        rd_chk(3 * 8 + 2, pack(3, 0, 1), "R2 readback off lo");
        rd_chk(3 * 8 + 3, pack(3, 1, 1), "R2 readback off hi");
        rd_chk(3 * 8 + 6, 32'h0, "R2 unmapped word");
        sweep("R3 shadow only");

        // R4 wrong update value ignored
        wr(3 * 8 + 5, 32'd2);
        @(negedge clk);
        sweep("R4 update value 2");

        // R4 commit timing on requester 5, aperture 2
        req_addr[5*32 +: 32] = {4'd2, low_of(5, 2)};
        wr(5 * 8 + 5, 32'd1);
        #1;
        chk_one(5, 2, "R4 first cycle old map");
        commit_model(5);
        @(negedge clk);
        #1;
        chk_one(5, 2, "R4 second cycle new map");

        // commit all but requester 11 (R10)
        for (int m = 0; m < NR - 1; m++) begin
            if (m != 5) begin
                wr(m * 8 + 5, 32'd1);
                commit_model(m);
            end
        end
        @(negedge clk);
        sweep("R10 committed except req11");

        // R8 boot control clear then set
        wr(4, 32'h0);
        m_boot = 2'b00;
        rd_chk(4, 32'h0, "R8 boot cleared readback");
        sweep("R8 boot clear");
        wr(4, 32'h2);
        m_boot = 2'b10;
        sweep("R8 boot set bit1");

        // R9 valid low
        @(negedge clk);
        req_valid = '0;
        #1;
        for (int m = 0; m < NR; m++) begin
            chk(tgt_sel[m*NT +: NT] == '0, "R9 sel idle", 64'(tgt_sel[m*NT +: NT]), 64'h0);
            chk(dec_err[m] == 1'b0, "R9 err idle", 64'(dec_err[m]), 64'h0);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule